// File: doc/BRIEF.md
# Keyed Write-Access Guard for a Clock-Control Register Space

This block sits between a single-cycle register port and the register file of a clock control unit. It holds one bit of state, the access flag, that decides whether writes may reach the protected registers. The flag lives in a control register at offset 0. A write to that register changes the flag only when a fixed 16-bit key sits in bits 23:8 of the write data. Bit 0 of the same write then says whether access is opened (1) or closed (0).

Writes to every other offset go out to the downstream register file with a qualified strobe. That strobe is raised only while access is open. Otherwise the write is dropped without any signal back to the bus. Reads are never blocked. Offset 0 returns the access flag, and every other offset returns the register file's read data unchanged.

Top module: `regwin_guard`

## Requirements
- R1: After a synchronous active-low reset the access flag is 0 (closed), so a read of offset 0 returns 0.
- R2: A write to offset 0 whose bits 23:8 equal 16'hA5A5 and whose bit 0 is 1 sets the access flag. The flag is visible from the cycle after the write.
- R3: A write to offset 0 whose bits 23:8 equal 16'hA5A5 and whose bit 0 is 0 clears the access flag. The flag is visible from the cycle after the write.
- R4: A write to offset 0 whose bits 23:8 differ from 16'hA5A5 leaves the access flag unchanged.
- R5: While the flag is 0, a write to any nonzero offset does not raise `reg_we`, and the register file keeps its contents.
- R6: While the flag is 1, a write to a nonzero offset raises `reg_we` in the same cycle. `reg_addr` and `reg_wdata` carry the bus address and data.
- R7: A write to offset 0 never raises `reg_we`.
- R8: A read of offset 0 returns the access flag in bit 0 and zeros in bits 31:1.
- R9: A read of any nonzero offset returns `reg_rdata` unchanged, whatever the state of the flag.
- R10: Bits 31:24 and 7:1 of a write to offset 0 do not affect whether the key matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset of the current access |
| bus_wdata | input | DATA_W | Write data from the bus |
| bus_we | input | 1 | Write strobe from the bus, single cycle |
| bus_rdata | output | DATA_W | Read data returned to the bus (combinational) |
| reg_addr | output | ADDR_W | Offset forwarded to the register file |
| reg_wdata | output | DATA_W | Write data forwarded to the register file |
| reg_we | output | 1 | Qualified write strobe to the register file |
| reg_rdata | input | DATA_W | Read data from the register file |

## Verification
The control write that flips the flag and the protected write it governs fall on adjacent cycles. The test also puts a read of offset 0 in the same cycle as a keyed control write. The bench drives back-to-back sequences of a keyed open, a protected write, a keyed close and another protected write. It then checks two things: the read in the cycle of a control write still shows the old flag, and the next cycle's protected write is passed or dropped according to the new flag. Random traffic mixes keys that miss, with random bits outside the key field, against a bench model of the flag and a shadow copy of the register file.

// File: rtl/regwin_guard_pkg.sv
// Package: shared constants and the decode record for the access guard.
// Assumes a 32-bit data path, with the key field placed inside it.
package regwin_guard_pkg;

    // Default key field placement and value in a control write
    localparam int KEY_LSB_DEF = 8;
    localparam int KEY_W_DEF   = 16;
    localparam logic [KEY_W_DEF-1:0] KEY_VAL_DEF = 16'hA5A5;

    // Decoded view of the current bus cycle
    typedef struct packed {
        logic ctrl_hit;   // access targets the control register
        logic key_ok;     // key field matches
        logic want_open;  // requested flag value (bit 0)
    } ctrl_dec_t;

endpackage

// File: rtl/regwin_guard_decode.sv
// Module: decodes a bus cycle into a control-register hit, a key match
// and the requested flag value. Purely combinational.
// Assumes the control register lives at CTRL_ADDR.
module regwin_guard_decode
    import regwin_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int KEY_W  = KEY_W_DEF,
    parameter logic [KEY_W-1:0]  KEY_VAL   = KEY_VAL_DEF[KEY_W-1:0],
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  key_field,
    input  logic              en_bit,
    output ctrl_dec_t         dec
);

    // Build the decode record from address and key field
    always_comb begin
        dec.ctrl_hit  = (addr == CTRL_ADDR);
        dec.key_ok    = (key_field == KEY_VAL);
        dec.want_open = en_bit;
    end

endmodule

// File: rtl/regwin_guard_state.sv
// Module: holds the access flag. A keyed write to the control register
// loads the requested value; anything else leaves the flag as it is.
// Assumes a synchronous active-low reset that closes access.
module regwin_guard_state
    import regwin_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  ctrl_dec_t dec,
    output logic      open_q
);

    logic load;

    // A keyed control write is the only way to change the flag
    always_comb load = we && dec.ctrl_hit && dec.key_ok;

    // Flag register with synchronous reset to closed
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (load)
            open_q <= dec.want_open;
    end

endmodule

// File: rtl/regwin_guard_rdmux.sv
// Module: selects read data - the flag at the control offset, the
// register file's data elsewhere. Combinational.
// Assumes the register file returns data in the same cycle.
module regwin_guard_rdmux #(
    parameter int DATA_W = 32
) (
    input  logic              ctrl_hit,
    input  logic              open_q,
    input  logic [DATA_W-1:0] file_rdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - 1;

    // Return the flag, zero-extended, or pass the file's data through
    always_comb begin
        if (ctrl_hit)
            rdata = {{PAD_W{1'b0}}, open_q};
        else
            rdata = file_rdata;
    end

endmodule

// File: rtl/regwin_guard.sv
// Top: guards writes to a clock-control register space behind a keyed
// access flag at offset 0. Forwards address and data to the register
// file, qualifies its write strobe and routes read data back.
// Assumes one access per cycle and a combinational register-file read.
module regwin_guard
    import regwin_guard_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int KEY_LSB = KEY_LSB_DEF,
    parameter int KEY_W   = KEY_W_DEF,
    parameter logic [KEY_W-1:0] KEY_VAL = KEY_VAL_DEF[KEY_W-1:0]
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    ctrl_dec_t dec;
    logic      open_q;

    regwin_guard_decode #(
        .ADDR_W    (ADDR_W),
        .KEY_W     (KEY_W),
        .KEY_VAL   (KEY_VAL),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .addr      (bus_addr),
        .key_field (bus_wdata[KEY_MSB:KEY_LSB]),
        .en_bit    (bus_wdata[0]),
        .dec       (dec)
    );

    regwin_guard_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .dec    (dec),
        .open_q (open_q)
    );

    regwin_guard_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .ctrl_hit   (dec.ctrl_hit),
        .open_q     (open_q),
        .file_rdata (reg_rdata),
        .rdata      (bus_rdata)
    );

    // Forward address and data; pass the strobe only for open, non-control writes
    always_comb begin
        reg_addr  = bus_addr;
        reg_wdata = bus_wdata;
        reg_we    = bus_we && !dec.ctrl_hit && open_q;
    end

endmodule

// File: rtl/regwin_guard_chk.sv
// Checker: temporal properties of the access guard, bound to the top.
module regwin_guard_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int KEY_LSB = 8,
    parameter int KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'hA5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              reg_we,
    input logic              open_q
);

    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    logic ctrl_wr;
    logic key_hit;
    always_comb begin
        ctrl_wr = bus_we && (bus_addr == '0);
        key_hit = (bus_wdata[KEY_MSB:KEY_LSB] == KEY_VAL);
    end

    // R1
    rst_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !open_q);

    // R2
    key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && key_hit && bus_wdata[0]) |=> open_q);

    // R3
    key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && key_hit && !bus_wdata[0]) |=> !open_q);

    // R4
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !key_hit) |=> $stable(open_q));

    // R5
    closed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |-> !reg_we);

    // R7
    ctrl_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> !reg_we);

    // R8
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[DATA_W-1:1] == '0 && bus_rdata[0] == open_q));

endmodule

bind regwin_guard regwin_guard_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_LSB (KEY_LSB),
    .KEY_W   (KEY_W),
    .KEY_VAL (KEY_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .reg_we    (reg_we),
    .open_q    (open_q)
);

// File: tb/regwin_guard_tb.sv
module regwin_guard_tb;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_we;
    logic [DW-1:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model state
    bit          exp_open = 1'b0;
    logic [DW-1:0] file_mem [16];
    logic [DW-1:0] exp_mem  [16];

    always #10 clk = ~clk;

    regwin_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Downstream register file model
    assign reg_rdata = file_mem[reg_addr[3:0]];
    always @(posedge clk) if (reg_we) file_mem[reg_addr[3:0]] <= reg_wdata;

    function automatic logic [DW-1:0] ctrl_word(input logic [15:0] key, input bit en,
                                                 input logic [7:0] hi, input logic [6:0] lo);
        return {hi, key, lo, en};
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (a == '0) return {31'b0, exp_open};
        return exp_mem[a[3:0]];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read one offset and compare with the model
    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #2;
        check(req, bus_rdata, exp_read(a));
    endtask

    // Control write; also checks same-cycle read of the old flag and no forwarding
    task automatic do_ctrl(input logic [DW-1:0] d, input string req);
        @(negedge clk);
        bus_addr = '0; bus_wdata = d; bus_we = 1'b1;
        #2;
        check("R7 ctrl write not forwarded", {31'b0, reg_we}, 32'd0);
        check("R8 same-cycle flag read", bus_rdata, {31'b0, exp_open});
        if (d[23:8] == 16'hA5A5) exp_open = d[0];
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    // Protected write; checks the strobe and forwarded fields
    task automatic do_data(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #2;
        if (exp_open) begin
            check("R6 strobe passed", {31'b0, reg_we}, 32'd1);
            check("R6 addr fwd", {24'b0, reg_addr}, {24'b0, a});
            check("R6 data fwd", reg_wdata, d);
            exp_mem[a[3:0]] = d;
        end else begin
            check("R5 strobe dropped", {31'b0, reg_we}, 32'd0);
        end
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 16; i++) begin
            file_mem[i] = 32'h1000_0000 + i;
            exp_mem[i]  = 32'h1000_0000 + i;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        do_read(8'd0, "R1 reset closed");
        // R5 writes dropped while closed, R9 reads still work
        do_data(8'd3, 32'hDEAD_0003);
        do_read(8'd3, "R5 closed write kept file");
        do_read(8'd5, "R9 read while closed");
        // R4 wrong key does not open
        do_ctrl(ctrl_word(16'hA5A4, 1'b1, 8'h00, 7'h0), "R4");
        do_read(8'd0, "R4 bad key held closed");
        // R2 open with noisy outer bits (R10)
        do_ctrl(ctrl_word(16'hA5A5, 1'b1, 8'hFF, 7'h7F), "R2");
        do_read(8'd0, "R2 R10 opened");
        // Adjacent-cycle: protected write right after open
        do_data(8'd3, 32'hCAFE_0003);
        do_read(8'd3, "R6 write landed");
        // R4 wrong key with bit0 clear does not close
        do_ctrl(ctrl_word(16'h5A5A, 1'b0, 8'h00, 7'h0), "R4");
        do_read(8'd0, "R4 bad key held open");
        // R3 close, then immediate protected write dropped
        do_ctrl(ctrl_word(16'hA5A5, 1'b0, 8'h3C, 7'h15), "R3");
        do_data(8'd7, 32'hBAD0_0007);
        do_read(8'd0, "R3 closed");
        do_read(8'd7, "R5 dropped after close");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [15:0] k;
            logic [AW-1:0] a;
            op = $urandom_range(0, 5);
            a  = AW'($urandom_range(1, 15));
            case (op)
                0: do_ctrl(ctrl_word(16'hA5A5, 1'b1, 8'($urandom), 7'($urandom)), "R2");
                1: do_ctrl(ctrl_word(16'hA5A5, 1'b0, 8'($urandom), 7'($urandom)), "R3");
                2: begin
                    k = 16'($urandom);
                    if (k == 16'hA5A5) k = 16'h0000;
                    do_ctrl(ctrl_word(k, 1'($urandom), 8'($urandom), 7'($urandom)), "R4");
                end
                3, 4: do_data(a, $urandom);
                default: do_read(($urandom_range(0, 3) == 0) ? 8'd0 : a, "R8 R9 random read");
            endcase
        end
        for (int i = 0; i < 16; i++) do_read(8'(i), "R9 final sweep");

        // R1 reset again while open
        do_ctrl(ctrl_word(16'hA5A5, 1'b1, 8'h00, 7'h0), "R2");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        exp_open = 1'b0;
        do_read(8'd0, "R1 reset closes");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule